// File: doc/BRIEF.md
# Link Retrain Sequencer

This block raises a serial point-to-point link to its second-generation speed once the link is out of reset. A single `start` pulse launches a fixed sequence on a small register bus. First the 32-bit capability register is read and rewritten so that the target-speed field asks for generation 2. Then two retrain passes follow. Each pass reads the 16-bit control register, writes it back with the retrain request bit set, and polls the 16-bit status register until the training flag drops. At the end of each pass the negotiated speed and lane width are taken from that final status word and shown on the outputs.

Each pass is guarded by a programmable count of status reads that may still show training. When that count is reached the sequencer stops, sets a sticky error flag and ends the run. The register bus allows one access at a time under a req/ack handshake, and read data is returned in the cycle in which ack is high.

Top module: `link_retrain_seq`

## Requirements
- R1: After reset `done`, `err`, `bus_req`, `link_speed` and `link_width` are all 0.
- R2: Each run begins by reading the capability register. It writes back `(value & ~32'h0003F00F) | 32'h2` before any access to the control register.
- R3: Each retrain pass reads the control register and writes back `{16'h0, value[15:0] | 16'h0020}`. Bit 5 is the retrain request, and all other low bits are left unchanged.
- R4: When no timeout occurs, a run performs exactly two retrain writes.
- R5: After a retrain write the status register is read again and again while bit 11 of the returned word is 1. The next pass, or the end of the run, follows only a read in which bit 11 is 0.
- R6: When a pass ends, `link_speed` takes status bits [3:0] and `link_width` takes status bits [8:4] from the read that ended it. The values from pass 1 are visible while pass 2 runs.
- R7: `done` is a one-cycle pulse at the end of a run. `link_speed` and `link_width` then hold their values until the next accepted start, which clears them to 0.
- R8: Within one pass, the status read that makes the number of reads showing bit 11 = 1 equal to `timeout_lim` ends the run with `err` = 1, and no further bus access follows. A limit of 0 acts as 1.
- R9: `err` stays 1 until the next accepted `start` and is cleared by that start.
- R10: At most one bus request is open at a time. `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold steady until `bus_ack`.
- R11: A `start` pulse that arrives while a run is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run (accepted only when idle) |
| timeout_lim | input | 16 | Busy status reads allowed per pass |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Sticky training-timeout flag |
| link_speed | output | 4 | Captured negotiated generation |
| link_width | output | 5 | Captured negotiated lane count |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 12 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete; read data valid |
| bus_rdata | input | 32 | Read data |

## Verification
A wrong state or pass counter appears on the bus within one access. It shows up as a missing capability update, a retrain write that is extra or absent, or a status read issued after a clear training flag. The register model counts each of these per run. A faulty read-modify-write shows in the very write it corrupts. A fault in capture or clearing shows on `link_speed`/`link_width` no later than the `done` pulse, and the mid-run sample taken at the second retrain write catches a first-pass capture that was lost. A broken timeout count gives the wrong number of status reads, or a wrong `err`, in that same run.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CAP_RD, S_CAP_RDW, S_CAP_WR, S_CAP_WRW,
    S_CTL_RD, S_CTL_RDW, S_CTL_WR, S_CTL_WRW,
    S_STS_RD, S_STS_RDW, S_FINISH
  } lrs_state_e;

  localparam int unsigned LRS_DW       = 32;
  localparam logic [31:0] CAP_CLR_MASK = 32'h0003_F00F;
  localparam logic [31:0] CAP_TARGET   = 32'h0000_0002;
  localparam int unsigned RETRAIN_POS  = 5;
  localparam int unsigned TRAINING_POS = 11;

  function automatic logic [31:0] cap_update(input logic [31:0] v);
    return (v & ~CAP_CLR_MASK) | CAP_TARGET;
  endfunction

  function automatic logic [31:0] ctl_update(input logic [31:0] v);
    logic [15:0] lo;
    lo = v[15:0];
    lo[RETRAIN_POS] = 1'b1;
    return {16'h0, lo};
  endfunction

  function automatic logic sts_training(input logic [31:0] v);
    return v[TRAINING_POS];
  endfunction

  function automatic logic [3:0] sts_speed(input logic [31:0] v);
    return v[3:0];
  endfunction

  function automatic logic [4:0] sts_width(input logic [31:0] v);
    return v[8:4];
  endfunction

  // true when this busy read brings the busy count up to the limit
  function automatic logic timed_out(input logic [31:0] seen, input logic [31:0] lim);
    logic [31:0] eff;
    eff = (lim == 32'd0) ? 32'd1 : lim;
    return (seen + 32'd1) >= eff;
  endfunction

endpackage

// File: rtl/lrs_bus_master.sv
module lrs_bus_master #(
  parameter int unsigned AW = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      issue,
  input  logic                      issue_we,
  input  logic [AW-1:0]             issue_addr,
  input  logic [lrs_pkg::LRS_DW-1:0] issue_wdata,
  output logic                      bus_req,
  output logic                      bus_we,
  output logic [AW-1:0]             bus_addr,
  output logic [lrs_pkg::LRS_DW-1:0] bus_wdata,
  input  logic                      bus_ack,
  input  logic [lrs_pkg::LRS_DW-1:0] bus_rdata,
  output logic                      rsp_valid,
  output logic [lrs_pkg::LRS_DW-1:0] rsp_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (bus_req && bus_ack) begin
      bus_req <= 1'b0;
    end else if (issue && !bus_req) begin
      bus_req   <= 1'b1;
      bus_we    <= issue_we;
      bus_addr  <= issue_addr;
      bus_wdata <= issue_wdata;
    end
  end

  assign rsp_valid = bus_req && bus_ack;
  assign rsp_data  = bus_rdata;

  // R10: request fields frozen while waiting for ack
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

endmodule

// File: rtl/lrs_poll_timer.sv
module lrs_poll_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          busy_hit,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  import lrs_pkg::*;

  logic [TW-1:0] seen_q;

  assign expired = busy_hit && timed_out(32'(seen_q), 32'(limit));

  always_ff @(posedge clk) begin
    if (!rst_n)                       seen_q <= '0;
    else if (clear)                   seen_q <= '0;
    else if (busy_hit && !expired)    seen_q <= seen_q + 1'b1;
  end

  // R8: a non-expiring busy read always leaves the count below the limit
  a_r8_count_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_hit && !expired && !clear && $stable(limit)) |=> (32'(seen_q) < 32'(limit)));

endmodule

// File: rtl/lrs_link_report.sv
module lrs_link_report (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        load,
  input  logic [31:0] sts,
  output logic [3:0]  speed,
  output logic [4:0]  width
);
  import lrs_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      speed <= '0;
      width <= '0;
    end else if (load) begin
      speed <= sts_speed(sts);
      width <= sts_width(sts);
    end
  end

  // R6: capture follows the status word that ended the pass
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> (speed == $past(sts[3:0]) && width == $past(sts[8:4])));

  // R7: outputs stay put between captures and starts
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clear) |=> ($stable(speed) && $stable(width)));

endmodule

// File: rtl/link_retrain_seq.sv
module link_retrain_seq #(
  parameter int unsigned          AW       = 12,
  parameter int unsigned          TW       = 16,
  parameter int unsigned          PASSES   = 2,
  parameter logic [AW-1:0]        CAP_ADDR = 12'h010,
  parameter logic [AW-1:0]        CTL_ADDR = 12'h014,
  parameter logic [AW-1:0]        STS_ADDR = 12'h016
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] timeout_lim,
  output logic          done,
  output logic          err,
  output logic [3:0]    link_speed,
  output logic [4:0]    link_width,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  input  logic          bus_ack,
  input  logic [31:0]   bus_rdata
);
  import lrs_pkg::*;

  localparam int unsigned    PW   = $clog2(PASSES + 1);
  localparam logic [PW-1:0]  LAST = PW'(PASSES - 1);

  lrs_state_e     state, nstate;
  logic [31:0]    data_q;
  logic [PW-1:0]  pass_q;
  logic           err_q;

  logic           issue, issue_we;
  logic [AW-1:0]  issue_addr;
  logic [31:0]    issue_wdata;
  logic           rsp_valid;
  logic [31:0]    rsp_data;

  // named internal events
  logic start_evt, poll_rsp, busy_hit, pass_end, expired, timer_clear;

  assign start_evt   = start && (state == S_IDLE);
  assign poll_rsp    = (state == S_STS_RDW) && rsp_valid;
  assign busy_hit    = poll_rsp && sts_training(rsp_data);
  assign pass_end    = poll_rsp && !sts_training(rsp_data);
  assign timer_clear = (state == S_CTL_WR);

  always_comb begin
    issue       = 1'b0;
    issue_we    = 1'b0;
    issue_addr  = CAP_ADDR;
    issue_wdata = '0;
    unique case (state)
      S_CAP_RD: begin issue = 1'b1; end
      S_CAP_WR: begin issue = 1'b1; issue_we = 1'b1; issue_wdata = cap_update(data_q); end
      S_CTL_RD: begin issue = 1'b1; issue_addr = CTL_ADDR; end
      S_CTL_WR: begin issue = 1'b1; issue_we = 1'b1; issue_addr = CTL_ADDR;
                      issue_wdata = ctl_update(data_q); end
      S_STS_RD: begin issue = 1'b1; issue_addr = STS_ADDR; end
      default: ;
    endcase
  end

  always_comb begin
    nstate = state;
    unique case (state)
      S_IDLE:    if (start) nstate = S_CAP_RD;
      S_CAP_RD:  nstate = S_CAP_RDW;
      S_CAP_RDW: if (rsp_valid) nstate = S_CAP_WR;
      S_CAP_WR:  nstate = S_CAP_WRW;
      S_CAP_WRW: if (rsp_valid) nstate = S_CTL_RD;
      S_CTL_RD:  nstate = S_CTL_RDW;
      S_CTL_RDW: if (rsp_valid) nstate = S_CTL_WR;
      S_CTL_WR:  nstate = S_CTL_WRW;
      S_CTL_WRW: if (rsp_valid) nstate = S_STS_RD;
      S_STS_RD:  nstate = S_STS_RDW;
      S_STS_RDW: begin
        if (busy_hit)      nstate = expired ? S_FINISH : S_STS_RD;
        else if (pass_end) nstate = (pass_q == LAST) ? S_FINISH : S_CTL_RD;
      end
      S_FINISH:  nstate = S_IDLE;
      default:   nstate = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      data_q <= '0;
      pass_q <= '0;
      err_q  <= 1'b0;
    end else begin
      state <= nstate;
      if (rsp_valid && (state == S_CAP_RDW || state == S_CTL_RDW)) data_q <= rsp_data;
      if (start_evt)     pass_q <= '0;
      else if (pass_end) pass_q <= pass_q + 1'b1;
      if (start_evt)     err_q <= 1'b0;
      else if (expired)  err_q <= 1'b1;
    end
  end

  assign done = (state == S_FINISH);
  assign err  = err_q;

  lrs_bus_master #(.AW(AW)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .issue(issue), .issue_we(issue_we), .issue_addr(issue_addr), .issue_wdata(issue_wdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  lrs_poll_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(timer_clear), .busy_hit(busy_hit),
    .limit(timeout_lim), .expired(expired)
  );

  lrs_link_report u_report (
    .clk(clk), .rst_n(rst_n), .clear(start_evt), .load(pass_end),
    .sts(rsp_data), .speed(link_speed), .width(link_width)
  );

  // R7: done lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: no bus activity once a timeout has been flagged
  a_r8_quiet_after_error: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !bus_req);

  // R4: pass counter never runs past the configured pass count
  a_r4_pass_limit: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pass_q) <= PASSES);

  // R5: a busy status read without timeout leads to another status read
  a_r5_keep_polling: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_hit && !expired) |=> (state == S_STS_RD));

  // R11: a start during a run never rewinds the pass count
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state != S_IDLE) |=> (pass_q >= $past(pass_q)));

endmodule

// File: tb/sim_link_retrain_seq.sv
module sim_link_retrain_seq;

  localparam logic [11:0] A_CAP = 12'h010;
  localparam logic [11:0] A_CTL = 12'h014;
  localparam logic [11:0] A_STS = 12'h016;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] timeout_lim = 16'd100;
  logic        done, err, bus_req, bus_we, bus_ack;
  logic [3:0]  link_speed;
  logic [4:0]  link_width;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #4 clk = ~clk;

  link_retrain_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .timeout_lim(timeout_lim),
    .done(done), .err(err), .link_speed(link_speed), .link_width(link_width),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int n_run = 0, n_fail = 0;

  // register model state
  logic [31:0] cap_reg;
  logic [15:0] ctl_reg;
  int          busy_left, pidx;
  int          bcnt [2];
  logic [3:0]  spv [2];
  logic [4:0]  wdv [2];
  logic [3:0]  cur_sp;
  logic [4:0]  cur_wd;
  int          n_cap_wr, n_ctl_wr, n_sts, ctl_bad, order_bad, cap_bad;
  logic [31:0] exp_cap;
  logic [3:0]  mid_sp;
  logic [4:0]  mid_wd;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_cap_fn(input logic [31:0] v);
    logic [31:0] r;
    r = v;
    r[3:0] = 4'd2;
    r[15:12] = 4'd0;
    r[17:16] = 2'd0;
    return r;
  endfunction

  function automatic logic [31:0] exp_ctl_fn(input logic [15:0] v);
    return {16'h0, v | 16'h0020};
  endfunction

  // register responder
  initial begin
    bus_ack = 1'b0;
    bus_rdata = '0;
    forever begin
      int dly;
      bit armed;
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
      end else if (rst_n && bus_req) begin
        if (!armed) begin dly = int'($urandom % 3); armed = 1'b1; end
        if (dly == 0) begin
          armed = 1'b0;
          if (bus_we) begin
            if (bus_addr == A_CAP) begin
              n_cap_wr++;
              if (bus_wdata != exp_cap) cap_bad++;
              cap_reg = bus_wdata;
            end else if (bus_addr == A_CTL) begin
              if (n_cap_wr == 0) order_bad++;
              n_ctl_wr++;
              if (bus_wdata != exp_ctl_fn(ctl_reg)) ctl_bad++;
              if (n_ctl_wr == 2) begin mid_sp = link_speed; mid_wd = link_width; end
              ctl_reg = bus_wdata[15:0] & ~16'h0020;
              busy_left = bcnt[pidx];
              cur_sp = spv[pidx];
              cur_wd = wdv[pidx];
              if (pidx < 1) pidx++;
            end
          end else begin
            if (bus_addr == A_CAP) bus_rdata = cap_reg;
            else if (bus_addr == A_CTL) begin
              if (n_cap_wr == 0) order_bad++;
              bus_rdata = {16'h0, ctl_reg};
            end else begin
              logic [31:0] junk;
              junk = $urandom;
              bus_rdata = {junk[31:16], junk[15:12], (busy_left != 0), junk[10:9], cur_wd, cur_sp};
              n_sts++;
              if (busy_left > 0) busy_left--;
            end
          end
          bus_ack = 1'b1;
        end else dly--;
      end
    end
  end

  // one run with expectations derived from the requirements
  task automatic run_seq(input int b0, input int b1, input logic [3:0] s0, input logic [4:0] w0,
                         input logic [3:0] s1, input logic [4:0] w1, input int lim, input bit inject);
    int eff, e_ctl, e_sts, n_done, cyc;
    bit e_err;
    logic [3:0] e_sp;
    logic [4:0] e_wd;
    cap_reg = $urandom; ctl_reg = 16'($urandom);
    exp_cap = exp_cap_fn(cap_reg);
    bcnt[0] = b0; bcnt[1] = b1; spv[0] = s0; spv[1] = s1; wdv[0] = w0; wdv[1] = w1;
    pidx = 0; busy_left = 0; cur_sp = 4'hF; cur_wd = 5'h1F;
    n_cap_wr = 0; n_ctl_wr = 0; n_sts = 0; ctl_bad = 0; order_bad = 0; cap_bad = 0;
    mid_sp = 0; mid_wd = 0;
    timeout_lim = 16'(lim);
    eff = (lim == 0) ? 1 : lim;
    if (b0 >= eff) begin e_ctl = 1; e_sts = eff; e_err = 1; e_sp = 0; e_wd = 0; end
    else if (b1 >= eff) begin e_ctl = 2; e_sts = b0 + 1 + eff; e_err = 1; e_sp = s0; e_wd = w0; end
    else begin e_ctl = 2; e_sts = b0 + b1 + 2; e_err = 0; e_sp = s1; e_wd = w1; end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n_done = 0; cyc = 0;
    while (n_done == 0 && cyc < 3000) begin
      if (inject && cyc == 6) start = 1'b1;
      else start = 1'b0;
      if (done) begin
        n_done++;
        chk(err == e_err, "R8/R9 err at done", 32'(err), 32'(e_err));
        chk(link_speed == e_sp, "R6 speed at done", 32'(link_speed), 32'(e_sp));
        chk(link_width == e_wd, "R6 width at done", 32'(link_width), 32'(e_wd));
      end
      @(negedge clk); cyc++;
    end
    start = 1'b0;
    chk(n_done == 1, "R7 done seen", 32'(n_done), 32'd1);
    chk(done == 1'b0, "R7 done one cycle", 32'(done), 32'd0);
    repeat (6) begin
      @(negedge clk);
      if (done) n_done++;
    end
    chk(n_done == 1, "R7/R11 single done", 32'(n_done), 32'd1);
    chk(n_cap_wr == 1 && cap_bad == 0, "R2 capability update", 32'(n_cap_wr + 16 * cap_bad), 32'd1);
    chk(order_bad == 0, "R2 cap before ctl", 32'(order_bad), 32'd0);
    chk(ctl_bad == 0, "R3 retrain RMW", 32'(ctl_bad), 32'd0);
    chk(n_ctl_wr == e_ctl, "R4/R8 retrain writes", 32'(n_ctl_wr), 32'(e_ctl));
    chk(n_sts == e_sts, "R5/R8 status reads", 32'(n_sts), 32'(e_sts));
    if (e_ctl == 2) begin
      chk(mid_sp == s0, "R6 pass1 speed mid-run", 32'(mid_sp), 32'(s0));
      chk(mid_wd == w0, "R6 pass1 width mid-run", 32'(mid_wd), 32'(w0));
    end
    chk(link_speed == e_sp && link_width == e_wd, "R7 hold after done",
        {23'd0, link_width, link_speed}, {23'd0, e_wd, e_sp});
    chk(err == e_err && bus_req == 1'b0, "R9 err sticky, bus quiet", {30'd0, err, bus_req}, {30'd0, e_err, 1'b0});
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_run++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !err && !bus_req, "R1 reset controls", {29'd0, done, err, bus_req}, 32'd0);
    chk(link_speed == 0 && link_width == 0, "R1 reset outputs", {23'd0, link_width, link_speed}, 32'd0);

    // directed corners
    run_seq(0, 0, 4'd1, 5'd4, 4'd2, 5'd4, 100, 1'b0);
    run_seq(3, 2, 4'd1, 5'd2, 4'd2, 5'd8, 100, 1'b1);    // R11 start mid-run
    run_seq(10, 0, 4'd1, 5'd1, 4'd2, 5'd1, 3, 1'b0);     // R8 timeout in pass 1
    repeat (4) @(negedge clk);
    chk(err == 1'b1, "R9 err held while idle", 32'(err), 32'd1);
    run_seq(1, 9, 4'd1, 5'd4, 4'd2, 5'd4, 4, 1'b0);      // R8 timeout in pass 2
    run_seq(1, 0, 4'd2, 5'd2, 4'd2, 5'd2, 0, 1'b0);      // R8 limit 0 acts as 1
    run_seq(2, 2, 4'd2, 5'd16, 4'd1, 5'd8, 3, 1'b0);     // just below limit, R9 cleared

    // random runs
    for (int i = 0; i < 10; i++) begin
      run_seq(int'($urandom % 6), int'($urandom % 6),
              4'(1 + $urandom % 3), 5'(1 + $urandom % 16),
              4'(1 + $urandom % 3), 5'(1 + $urandom % 16),
              int'(2 + $urandom % 6), ($urandom % 2) == 1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule